// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the integer register file of a 64-bit core. It offers two combinational read ports and one write port, all usable in the same cycle. Thirty-one architectural registers, numbered 0 to 30, live in a main array, and register number 31 is a constant zero.

A privileged-mode input changes where a few register numbers land. While the input is high, numbers 8 through 14 and number 25 reach a separate bank of eight shadow registers, and all other numbers still reach the main array. Privileged code can therefore use scratch registers without saving the values that the interrupted code left in those same numbers.

Each port looks up its own number against the mode value present in that cycle. A write takes effect at the rising clock edge. A read in the same cycle as a write returns the value from before the write.

Top module: `banked_gpr`

## Requirements
- R1: With `priv_mode` low, every register number from 0 to 30 reads and writes the main array entry of that number.
- R2: With `priv_mode` high, register numbers 8 to 14 reach shadow slot (number − 8). Those main array entries are neither read nor written.
- R3: With `priv_mode` high, register number 25 reaches shadow slot 7 and leaves main array entry 25 untouched.
- R4: With `priv_mode` high, every number in 0–7, 15–24 and 26–30 reaches the same main array entry it reaches with `priv_mode` low.
- R5: When `wr_en` is high at a rising edge, `wr_data` is stored at the location of `wr_idx`. A read of that location from the next cycle on returns it.
- R6: Register number 31 always reads as 0 on both ports. A write to it changes no main or shadow entry.
- R7: When `wr_en` is low at a rising edge, no main or shadow entry changes, whatever the values on `wr_idx` and `wr_data`.
- R8: The bank is chosen by `priv_mode` in the cycle of each access. A value written in one mode stays in the bank it went to when the mode later changes, and the two read ports resolve independently.
- R9: A read of the location being written in the same cycle returns the value from before the write (no bypass).
- R10: While `rst_n` is low, all 31 main entries and all 8 shadow entries clear to zero. Reads after reset return 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 1 | High selects the shadow bank for numbers 8–14 and 25 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number to write |
| wr_data | input | 64 | Data to write |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | 64 | Read port A data, combinational |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | 64 | Read port B data, combinational |

## Verification
The bench fills the same register numbers with different values in the two modes. It then reads them back in both modes, so a design that ignores the mode, or banks the wrong numbers, returns the other bank's value. Register 25 and the edges of the 8–14 range (7, 8, 14, 15) get their own directed cases; an off-by-one slot mapping shows up there as a clobbered neighbour or a wrong slot. Writes to number 31 and writes with the enable low are followed by reads of every entry, which catches stray stores. Same-cycle read-and-write collisions would expose a bypass, because the design would return the new value one cycle early.

// File: rtl/banked_gpr_pkg.sv
package banked_gpr_pkg;

  localparam int GPR_XLEN     = 64;
  localparam int GPR_IDX_W    = 5;
  localparam int GPR_ARCH_N   = 31;
  localparam int GPR_ZERO_IDX = 31;
  localparam int GPR_SHADOW_N = 8;
  localparam int GPR_SLOT_W   = $clog2(GPR_SHADOW_N);
  // banking windows: a contiguous run plus one extra number
  localparam int GPR_RUN_LO   = 8;
  localparam int GPR_RUN_HI   = 14;
  localparam int GPR_EXTRA    = 25;
  localparam int GPR_EXTRA_SLOT = GPR_SHADOW_N - 1;

  typedef struct packed {
    logic                  zero;
    logic                  shadow;
    logic [GPR_SLOT_W-1:0] slot;
  } gpr_loc_t;

  function automatic gpr_loc_t gpr_locate(input logic priv,
                                          input logic [GPR_IDX_W-1:0] idx);
    gpr_loc_t loc;
    logic in_run, is_extra;
    in_run   = (idx >= GPR_IDX_W'(GPR_RUN_LO)) && (idx <= GPR_IDX_W'(GPR_RUN_HI));
    is_extra = (idx == GPR_IDX_W'(GPR_EXTRA));
    loc.zero   = (idx == GPR_IDX_W'(GPR_ZERO_IDX));
    loc.shadow = priv && (in_run || is_extra);
    loc.slot   = is_extra ? GPR_SLOT_W'(GPR_EXTRA_SLOT)
                          : GPR_SLOT_W'(idx - GPR_IDX_W'(GPR_RUN_LO));
    return loc;
  endfunction

endpackage

// File: rtl/gpr_map.sv
module gpr_map
  import banked_gpr_pkg::*;
(
  input  logic                 priv,
  input  logic [GPR_IDX_W-1:0] idx,
  output gpr_loc_t             loc
);
  assign loc = gpr_locate(priv, idx);
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8,
  parameter int NRD   = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rdata
);
  localparam bit FULL = ((1 << AW) == DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)                        mem[r] <= '0;
      else if (we && waddr == AW'(r))    mem[r] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    if (FULL) begin : g_full
      assign rdata[p] = mem[raddr[p]];
    end else begin : g_part
      assign rdata[p] = (raddr[p] < AW'(DEPTH)) ? mem[raddr[p]] : '0;
    end
  end
endmodule

// File: rtl/banked_gpr.sv
module banked_gpr
  import banked_gpr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 priv_mode,
  input  logic                 wr_en,
  input  logic [GPR_IDX_W-1:0] wr_idx,
  input  logic [GPR_XLEN-1:0]  wr_data,
  input  logic [GPR_IDX_W-1:0] rd_a_idx,
  output logic [GPR_XLEN-1:0]  rd_a_data,
  input  logic [GPR_IDX_W-1:0] rd_b_idx,
  output logic [GPR_XLEN-1:0]  rd_b_data
);
  localparam int NRD = 2;

  logic [NRD-1:0][GPR_IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][GPR_XLEN-1:0]   rd_out;
  gpr_loc_t                       rd_loc [NRD];
  logic [NRD-1:0][GPR_IDX_W-1:0]  main_raddr;
  logic [NRD-1:0][GPR_SLOT_W-1:0] sh_raddr;
  logic [NRD-1:0][GPR_XLEN-1:0]   main_rdata;
  logic [NRD-1:0][GPR_XLEN-1:0]   sh_rdata;

  gpr_loc_t wr_loc;
  logic     wr_main_hit;
  logic     wr_shadow_hit;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    gpr_map u_map (.priv(priv_mode), .idx(rd_idx[p]), .loc(rd_loc[p]));
    assign main_raddr[p] = rd_idx[p];
    assign sh_raddr[p]   = rd_loc[p].slot;
    assign rd_out[p] = rd_loc[p].zero   ? '0 :
                       rd_loc[p].shadow ? sh_rdata[p] : main_rdata[p];
  end

  gpr_map u_wmap (.priv(priv_mode), .idx(wr_idx), .loc(wr_loc));

  assign wr_main_hit   = wr_en && !wr_loc.zero && !wr_loc.shadow;
  assign wr_shadow_hit = wr_en && wr_loc.shadow;

  gpr_array #(.WIDTH(GPR_XLEN), .DEPTH(GPR_ARCH_N), .NRD(NRD)) u_main (
    .clk(clk), .rst_n(rst_n), .we(wr_main_hit), .waddr(wr_idx),
    .wdata(wr_data), .raddr(main_raddr), .rdata(main_rdata)
  );

  gpr_array #(.WIDTH(GPR_XLEN), .DEPTH(GPR_SHADOW_N), .NRD(NRD)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(wr_shadow_hit), .waddr(wr_loc.slot),
    .wdata(wr_data), .raddr(sh_raddr), .rdata(sh_rdata)
  );

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];
endmodule

// File: rtl/banked_gpr_chk.sv
module banked_gpr_chk
  import banked_gpr_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 priv_mode,
  input logic                 wr_en,
  input logic [GPR_IDX_W-1:0] wr_idx,
  input logic [GPR_XLEN-1:0]  wr_data,
  input logic [GPR_IDX_W-1:0] rd_a_idx,
  input logic [GPR_XLEN-1:0]  rd_a_data,
  input logic [GPR_IDX_W-1:0] rd_b_idx,
  input logic [GPR_XLEN-1:0]  rd_b_data,
  input logic                 wr_main_hit,
  input logic                 wr_shadow_hit
);
  localparam logic [GPR_IDX_W-1:0] ZIDX = GPR_IDX_W'(GPR_ZERO_IDX);
  localparam logic [GPR_IDX_W-1:0] XIDX = GPR_IDX_W'(GPR_EXTRA);

  a_r6_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == ZIDX) |-> (rd_a_data == '0));
  a_r6_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == ZIDX) |-> (rd_b_data == '0));
  a_r6_zero_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == ZIDX) |-> !(wr_main_hit || wr_shadow_hit));
  a_r7_no_write_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !(wr_main_hit || wr_shadow_hit));
  a_r2_one_bank_per_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_main_hit && wr_shadow_hit));
  a_r1_normal_mode_main_only: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_mode |-> !wr_shadow_hit);
  a_r5_write_visible_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != ZIDX) |=>
      ((rd_a_idx != $past(wr_idx)) || (priv_mode != $past(priv_mode)) ||
       (rd_a_data == $past(wr_data))));
  a_r3_extra_to_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv_mode && wr_idx == XIDX) |-> (wr_shadow_hit && !wr_main_hit));
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(rd_b_idx) && $stable(priv_mode)) |-> $stable(rd_b_data));
endmodule

bind banked_gpr banked_gpr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_main_hit(wr_main_hit), .wr_shadow_hit(wr_shadow_hit)
);

// File: tb/sim_banked_gpr.sv
`timescale 1ns/1ps
module sim_banked_gpr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_a_idx = '0;
  logic [63:0] rd_a_data;
  logic [4:0]  rd_b_idx = '0;
  logic [63:0] rd_b_data;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_main [32];
  logic [63:0] m_sh   [8];

  always #2.5 clk = ~clk;

  banked_gpr u0 (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
  );

  // shadow slot for a number in a mode, -1 when it uses the main array
  function automatic int slot_of(bit p, int n);
    if (!p) return -1;
    case (n)
      8, 9, 10, 11, 12, 13, 14: return n - 8;
      25:                       return 7;
      default:                  return -1;
    endcase
  endfunction

  function automatic logic [63:0] expect_rd(bit p, int n);
    int s = slot_of(p, n);
    if (n == 31) return 64'd0;
    if (s >= 0)  return m_sh[s];
    return m_main[n];
  endfunction

  function automatic string tag_of(bit p, int n);
    int s = slot_of(p, n);
    if (n == 31) return "R6";
    if (s == 7)  return "R3";
    if (s >= 0)  return "R2";
    if (p)       return "R4";
    return "R1";
  endfunction

  task automatic model_write(bit p, bit we, int n, logic [63:0] d);
    int s = slot_of(p, n);
    if (!we || n == 31) return;
    if (s >= 0) m_sh[s] = d;
    else        m_main[n] = d;
  endtask

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle: drive, check the reads, then model the write at the edge
  task automatic step(bit p, bit we, int wi, logic [63:0] wd, int ra, int rb, string why);
    @(negedge clk);
    priv_mode = p; wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    #1;
    check((why == "") ? tag_of(p, ra) : why, rd_a_data, expect_rd(p, ra));
    check((why == "") ? tag_of(p, rb) : why, rd_b_data, expect_rd(p, rb));
    @(posedge clk);
    model_write(p, we, wi, wd);
  endtask

  task automatic sweep(bit p, string why);
    for (int i = 0; i < 32; i += 2) step(p, 1'b0, 0, 64'd0, i, i + 1, why);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 32; i++) m_main[i] = '0;
    for (int i = 0; i < 8; i++)  m_sh[i] = '0;
    // R10: give the store junk first, then reset it
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_idx = 5'd3; wr_data = 64'hdead;
    @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    sweep(1'b0, "R10");
    sweep(1'b1, "R10");

    // R1/R5: fill the main array in normal mode
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, i, 64'h1000_0000_0000_0000 | 64'(i), 0, 1, "");
    sweep(1'b0, "R1");
    // R2/R3: fill shadow bank in privileged mode, main array untouched
    for (int i = 8; i <= 14; i++) step(1'b1, 1'b1, i, 64'h5a00_0000_0000_0000 | 64'(i), 7, 15, "R2");
    step(1'b1, 1'b1, 25, 64'h5a5a_0000_0000_0025, 24, 26, "R3");
    sweep(1'b1, "");
    sweep(1'b0, "R4");
    // R6: write to 31 is dropped in both modes
    step(1'b0, 1'b1, 31, 64'hffff_ffff_ffff_ffff, 31, 30, "R6");
    step(1'b1, 1'b1, 31, 64'hffff_ffff_ffff_ffff, 31, 25, "R6");
    sweep(1'b0, "R6");
    sweep(1'b1, "R6");
    // R7: enable low with live index/data changes nothing
    step(1'b1, 1'b0, 9, 64'hbad0, 9, 25, "R7");
    step(1'b0, 1'b0, 9, 64'hbad1, 9, 25, "R7");
    step(1'b0, 1'b0, 0, 64'd0, 9, 25, "R7");
    step(1'b1, 1'b0, 0, 64'd0, 9, 25, "R7");
    // R9: read the number being written, same cycle, old value then new
    step(1'b0, 1'b1, 5, 64'h0909_0909, 5, 5, "R9");
    step(1'b0, 1'b0, 0, 64'd0, 5, 5, "R9");
    step(1'b1, 1'b1, 14, 64'h1414_1414, 14, 14, "R9");
    step(1'b1, 1'b0, 0, 64'd0, 14, 14, "R9");
    // R8: bank is fixed at the write edge; ports resolve independently
    step(1'b1, 1'b1, 10, 64'hcafe_0010, 10, 2, "R8");
    step(1'b0, 1'b0, 0, 64'd0, 10, 25, "R8");
    step(1'b1, 1'b0, 0, 64'd0, 10, 3, "R8");
    step(1'b0, 1'b1, 10, 64'hbeef_0010, 10, 10, "R8");
    step(1'b1, 1'b0, 0, 64'd0, 10, 25, "R8");
    step(1'b0, 1'b0, 0, 64'd0, 10, 25, "R8");

    // constrained random: numbers drawn toward the bank edges half the time
    for (int k = 0; k < 3000; k++) begin
      int pick[8] = '{7, 8, 14, 15, 24, 25, 26, 31};
      bit p  = 1'($urandom % 2);
      bit we = ($urandom % 4) != 0;
      int wi = ($urandom % 2) ? pick[$urandom % 8] : int'($urandom % 32);
      int ra = ($urandom % 2) ? pick[$urandom % 8] : int'($urandom % 32);
      int rb = ($urandom % 3 == 0) ? wi : int'($urandom % 32);
      logic [63:0] wd = {$urandom, $urandom};
      step(p, we, wi, wd, ra, rb, (rb == wi && we) ? "R9" : "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule